// File: doc/BRIEF.md
# Panel power sequencer

This block walks a display panel from its powered-off condition to an active picture and back again. It does so by issuing an ordered series of register writes through an external serial command writer, and it pauses for a fixed number of clock cycles where the panel needs time to settle. The series is held in a small computed table of entries. Each entry carries a register address, a payload length of zero, one or two bytes, the payload itself, a flag asking for a pause after the entry, and a flag that marks a failure on that entry as fatal.

A single-cycle pulse on `enable_req` starts the power-up series. A pulse on `disable_req` starts the short power-down series. The block reports its phase on `pwr_state`, using 0 for disabled, 1 for enabling, 2 for active and 3 for disabling. A failure reported by the command writer during power-up ends with `pwr_error` high and the panel back in the disabled phase. The internal controller has five named states:
- OFF is the idle disabled state. `enable_req` takes it to UP_CMD.
- UP_CMD presents a power-up command. Its done either moves on to the next entry, goes to UP_WAIT when the entry asks for a pause, returns to OFF on an abort or a failed finish, or goes to ON after the last entry.
- UP_WAIT counts the pause. When the timer expires it returns to UP_CMD.
- ON is the active state. `disable_req` takes it to DN_CMD.
- DN_CMD presents the power-down commands. After the last one it returns to OFF.

Top module: `panel_power_seq`

## Requirements
- R1: After reset, `pwr_state` is 0 (disabled), `pwr_error` is low and `cmd_valid` is low.
- R2: An `enable_req` pulse while disabled moves `pwr_state` to 1 and issues, in this order, these commands (address/length/payload):
  - three times 0x00/0;
  - then 0xB0/1/0x17, 0xBC/1/0x80, 0x3B/1/0x00, 0xB0/1/0x16, 0xB8/2/0xFFF9 and 0x11/0;
  - then the setup writes 0xBA/1/0x01, 0x3A/1/0x60, 0xC3/2/0x2040, 0xC4/2/0x60C0, 0xD3/2/0x0D0E and 0xD4/2/0x11A4;
  - then 0x29/0.
  A one-byte payload appears on `cmd_data[7:0]` with the upper byte zero. A zero-length command drives `cmd_data` to zero.
- R3: After each of the three leading 0x00 commands completes, `cmd_valid` stays low for at least `DELAY_CYCLES` clock cycles before the next command appears.
- R4: While `cmd_valid` is high and `cmd_done` has not been seen, `cmd_valid`, `cmd_addr`, `cmd_len` and `cmd_data` hold steady. A command is complete in the cycle where `cmd_done` is high, and `cmd_fail` is sampled in that same cycle.
- R5: If any of the three leading 0x00 commands completes with `cmd_fail` high, no further command is issued. `pwr_state` returns to 0 and `pwr_error` rises.
- R6: A failure on any later power-up command does not stop the series, which runs through 0x29. `pwr_state` then returns to 0 with `pwr_error` high.
- R7: A power-up series that completes without any failure leaves `pwr_state` at 2 and `pwr_error` low.
- R8: A `disable_req` pulse while active moves `pwr_state` to 3 and issues 0x28/0, 0xB8/2/0x8002, 0x10/0 and 0xB0/1/0x00, in that order. `pwr_state` then becomes 0. Failures during power-down are ignored and leave `pwr_error` low.
- R9: An `enable_req` while enabling, active or disabling has no effect. A `disable_req` while disabled or enabling has no effect.
- R10: `pwr_error` is high only while disabled. It is cleared when the next `enable_req` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_req | input | 1 | Pulse requesting power-up |
| disable_req | input | 1 | Pulse requesting power-down |
| cmd_valid | output | 1 | A command is presented to the writer |
| cmd_addr | output | 8 | Register address of the command |
| cmd_len | output | 2 | Payload length in bytes (0, 1 or 2) |
| cmd_data | output | 16 | Payload; one byte sits in the low half |
| cmd_done | input | 1 | Writer finished the presented command |
| cmd_fail | input | 1 | Writer failure flag, valid with `cmd_done` |
| pwr_state | output | 2 | 0 disabled, 1 enabling, 2 active, 3 disabling |
| pwr_error | output | 1 | Last power-up attempt failed |

## Verification
The assertions assume that the command writer raises `cmd_done` only while `cmd_valid` is high, for a single cycle per command. They also assume that the request inputs are single-cycle pulses. The bench writer model follows both rules: it waits a random latency of zero to three cycles after seeing a command, then pulses done once, with the failure flag placed on one chosen command index. Requests are driven as one-cycle pulses, some of them deliberately while the block is busy. The pause length is shortened through the `DELAY_CYCLES` parameter so that the pauses stay inside the run length.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int LEN_W      = 2;
    localparam int UP_COUNT   = 16;
    localparam int DOWN_COUNT = 4;
    localparam int ROM_DEPTH  = UP_COUNT + DOWN_COUNT;
    localparam int IDX_W      = $clog2(ROM_DEPTH);

    typedef enum logic [1:0] {
        PWR_OFF     = 2'd0,
        PWR_RISING  = 2'd1,
        PWR_ON      = 2'd2,
        PWR_FALLING = 2'd3
    } pwr_phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
        logic              pause_after;
        logic              fatal;
    } seq_entry_t;

    function automatic seq_entry_t mk(input logic [7:0] a, input logic [1:0] l,
                                      input logic [15:0] d, input logic p, input logic f);
        seq_entry_t e;
        e.addr        = a;
        e.len         = l;
        e.data        = d;
        e.pause_after = p;
        e.fatal       = f;
        return e;
    endfunction

    // Entries 0..UP_COUNT-1 form power-up, the rest power-down.
    function automatic seq_entry_t seq_rom_entry(input int idx);
        unique case (idx)
            0:  return mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b1);
            1:  return mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b1);
            2:  return mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b1);
            3:  return mk(8'hB0, 2'd1, 16'h0017, 1'b0, 1'b0);
            4:  return mk(8'hBC, 2'd1, 16'h0080, 1'b0, 1'b0);
            5:  return mk(8'h3B, 2'd1, 16'h0000, 1'b0, 1'b0);
            6:  return mk(8'hB0, 2'd1, 16'h0016, 1'b0, 1'b0);
            7:  return mk(8'hB8, 2'd2, 16'hFFF9, 1'b0, 1'b0);
            8:  return mk(8'h11, 2'd0, 16'h0000, 1'b0, 1'b0);
            9:  return mk(8'hBA, 2'd1, 16'h0001, 1'b0, 1'b0);
            10: return mk(8'h3A, 2'd1, 16'h0060, 1'b0, 1'b0);
            11: return mk(8'hC3, 2'd2, 16'h2040, 1'b0, 1'b0);
            12: return mk(8'hC4, 2'd2, 16'h60C0, 1'b0, 1'b0);
            13: return mk(8'hD3, 2'd2, 16'h0D0E, 1'b0, 1'b0);
            14: return mk(8'hD4, 2'd2, 16'h11A4, 1'b0, 1'b0);
            15: return mk(8'h29, 2'd0, 16'h0000, 1'b0, 1'b0);
            16: return mk(8'h28, 2'd0, 16'h0000, 1'b0, 1'b0);
            17: return mk(8'hB8, 2'd2, 16'h8002, 1'b0, 1'b0);
            18: return mk(8'h10, 2'd0, 16'h0000, 1'b0, 1'b0);
            19: return mk(8'hB0, 2'd1, 16'h0000, 1'b0, 1'b0);
            default: return mk(8'h00, 2'd0, 16'h0000, 1'b0, 1'b0);
        endcase
    endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
    import panel_seq_pkg::*;
#(
    parameter int DEPTH = ROM_DEPTH,
    parameter int AW    = IDX_W
) (
    input  logic [AW-1:0] idx,
    output seq_entry_t    entry
);

    seq_entry_t table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign table_q[g] = seq_rom_entry(g);
    end

    always_comb begin
        if (int'(idx) < DEPTH) entry = table_q[idx];
        else                   entry = '0;
    end

endmodule

// File: rtl/panel_delay_timer.sv
module panel_delay_timer #(
    parameter int CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;
    logic          armed;

    assign expired = armed && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= CW'(CYCLES - 1);
            armed <= 1'b1;
        end else if (expired) begin
            armed <= 1'b0;
        end else if (armed) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/panel_seq_fsm.sv
module panel_seq_fsm
    import panel_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_req,
    input  logic             disable_req,
    input  logic             cmd_done,
    input  logic             cmd_fail,
    input  seq_entry_t       entry,
    input  logic             tmr_expired,
    output logic [IDX_W-1:0] idx,
    output logic             tmr_load,
    output logic             cmd_valid,
    output pwr_phase_e       phase,
    output logic             error
);

    localparam logic [IDX_W-1:0] UP_LAST  = IDX_W'(UP_COUNT - 1);
    localparam logic [IDX_W-1:0] DN_FIRST = IDX_W'(UP_COUNT);
    localparam logic [IDX_W-1:0] DN_LAST  = IDX_W'(ROM_DEPTH - 1);

    typedef enum logic [2:0] {
        OFF     = 3'd0,
        UP_CMD  = 3'd1,
        UP_WAIT = 3'd2,
        ON      = 3'd3,
        DN_CMD  = 3'd4
    } seq_state_e;

    seq_state_e       cur, nxt;
    logic [IDX_W-1:0] idx_n;
    logic             acc_q, acc_n;
    logic             err_n;

    always_comb begin
        nxt   = cur;
        idx_n = idx;
        acc_n = acc_q;
        err_n = error;
        unique case (cur)
            OFF: begin
                if (enable_req) begin
                    nxt   = UP_CMD;
                    idx_n = '0;
                    acc_n = 1'b0;
                    err_n = 1'b0;
                end
            end
            UP_CMD: begin
                if (cmd_done) begin
                    acc_n = acc_q | cmd_fail;
                    if (cmd_fail && entry.fatal) begin
                        nxt   = OFF;
                        err_n = 1'b1;
                    end else if (entry.pause_after) begin
                        nxt = UP_WAIT;
                    end else if (idx == UP_LAST) begin
                        if (acc_q || cmd_fail) begin
                            nxt   = OFF;
                            err_n = 1'b1;
                        end else begin
                            nxt = ON;
                        end
                    end else begin
                        idx_n = idx + 1'b1;
                    end
                end
            end
            UP_WAIT: begin
                if (tmr_expired) begin
                    nxt   = UP_CMD;
                    idx_n = idx + 1'b1;
                end
            end
            ON: begin
                if (disable_req) begin
                    nxt   = DN_CMD;
                    idx_n = DN_FIRST;
                end
            end
            DN_CMD: begin
                if (cmd_done) begin
                    if (idx == DN_LAST) nxt = OFF;
                    else                idx_n = idx + 1'b1;
                end
            end
            default: nxt = OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= OFF;
            idx   <= '0;
            acc_q <= 1'b0;
            error <= 1'b0;
        end else begin
            cur   <= nxt;
            idx   <= idx_n;
            acc_q <= acc_n;
            error <= err_n;
        end
    end

    always_comb begin
        cmd_valid = 1'b0;
        tmr_load  = 1'b0;
        phase     = PWR_OFF;
        unique case (cur)
            OFF:     phase = PWR_OFF;
            UP_CMD: begin
                phase     = PWR_RISING;
                cmd_valid = 1'b1;
                tmr_load  = cmd_done && entry.pause_after && !(cmd_fail && entry.fatal);
            end
            UP_WAIT: phase = PWR_RISING;
            ON:      phase = PWR_ON;
            DN_CMD: begin
                phase     = PWR_FALLING;
                cmd_valid = 1'b1;
            end
            default: phase = PWR_OFF;
        endcase
    end

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
    import panel_seq_pkg::*;
#(
    parameter int DELAY_CYCLES = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_req,
    input  logic              disable_req,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_done,
    input  logic              cmd_fail,
    output logic [1:0]        pwr_state,
    output logic              pwr_error
);

    logic [IDX_W-1:0] step;
    seq_entry_t       cur_entry;
    logic             tmr_load;
    logic             tmr_expired;
    pwr_phase_e       phase;

    panel_seq_rom #(
        .DEPTH (ROM_DEPTH),
        .AW    (IDX_W)
    ) u_rom (
        .idx   (step),
        .entry (cur_entry)
    );

    panel_delay_timer #(
        .CYCLES (DELAY_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    panel_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_req  (enable_req),
        .disable_req (disable_req),
        .cmd_done    (cmd_done),
        .cmd_fail    (cmd_fail),
        .entry       (cur_entry),
        .tmr_expired (tmr_expired),
        .idx         (step),
        .tmr_load    (tmr_load),
        .cmd_valid   (cmd_valid),
        .phase       (phase),
        .error       (pwr_error)
    );

    assign cmd_addr  = cmd_valid ? cur_entry.addr : '0;
    assign cmd_len   = cmd_valid ? cur_entry.len  : '0;
    assign cmd_data  = cmd_valid ? cur_entry.data : '0;
    assign pwr_state = phase;

endmodule

// File: rtl/panel_power_seq_chk.sv
module panel_power_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [7:0]  cmd_addr,
    input logic [1:0]  cmd_len,
    input logic [15:0] cmd_data,
    input logic        cmd_done,
    input logic [1:0]  pwr_state,
    input logic        pwr_error
);

    assert_hold_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=>
            (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_data)));

    assert_cmd_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (pwr_state == 2'd1 || pwr_state == 2'd3));

    assert_off_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0) |=> (pwr_state == 2'd0 || pwr_state == 2'd1));

    assert_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2) |=> (pwr_state == 2'd2 || pwr_state == 2'd3));

    assert_up_no_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1) |=> (pwr_state != 2'd3));

    assert_down_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3) |=> ((pwr_state == 2'd3 || pwr_state == 2'd0) && !pwr_error));

    assert_error_only_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_error |-> (pwr_state == 2'd0));

endmodule

bind panel_power_seq panel_power_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_data  (cmd_data),
    .cmd_done  (cmd_done),
    .pwr_state (pwr_state),
    .pwr_error (pwr_error)
);

// File: tb/panel_power_seq_test.sv
`timescale 1ns/1ps
module panel_power_seq_test;

    localparam int DLY = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_req = 1'b0;
    logic        disable_req = 1'b0;
    logic        cmd_valid;
    logic [7:0]  cmd_addr;
    logic [1:0]  cmd_len;
    logic [15:0] cmd_data;
    logic        cmd_done = 1'b0;
    logic        cmd_fail = 1'b0;
    logic [1:0]  pwr_state;
    logic        pwr_error;

    int n_checks = 0;
    int n_fail   = 0;
    int cmd_count = 0;
    int fail_at  = -1;
    int idle     = 0;
    logic [25:0] cmd_log  [32];
    int          idle_log [32];

    always #4 clk = ~clk;

    panel_power_seq #(.DELAY_CYCLES(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .enable_req(enable_req), .disable_req(disable_req),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .cmd_done(cmd_done), .cmd_fail(cmd_fail), .pwr_state(pwr_state), .pwr_error(pwr_error)
    );

    // expected command list: {addr, len, data}
    function automatic logic [25:0] exp_cmd(input int i);
        case (i)
            0, 1, 2: return {8'h00, 2'd0, 16'h0000};
            3:  return {8'hB0, 2'd1, 16'h0017};
            4:  return {8'hBC, 2'd1, 16'h0080};
            5:  return {8'h3B, 2'd1, 16'h0000};
            6:  return {8'hB0, 2'd1, 16'h0016};
            7:  return {8'hB8, 2'd2, 16'hFFF9};
            8:  return {8'h11, 2'd0, 16'h0000};
            9:  return {8'hBA, 2'd1, 16'h0001};
            10: return {8'h3A, 2'd1, 16'h0060};
            11: return {8'hC3, 2'd2, 16'h2040};
            12: return {8'hC4, 2'd2, 16'h60C0};
            13: return {8'hD3, 2'd2, 16'h0D0E};
            14: return {8'hD4, 2'd2, 16'h11A4};
            15: return {8'h29, 2'd0, 16'h0000};
            16: return {8'h28, 2'd0, 16'h0000};
            17: return {8'hB8, 2'd2, 16'h8002};
            18: return {8'h10, 2'd0, 16'h0000};
            19: return {8'hB0, 2'd1, 16'h0000};
            default: return '0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // command writer model
    initial begin
        @(negedge clk);
        forever begin
            if (rst_n && cmd_valid) begin
                if (cmd_count < 32) begin
                    cmd_log[cmd_count]  = {cmd_addr, cmd_len, cmd_data};
                    idle_log[cmd_count] = idle;
                end
                repeat ($urandom_range(3, 0)) @(negedge clk);
                cmd_done = 1'b1;
                cmd_fail = (cmd_count == fail_at);
                cmd_count++;
                idle = 0;
                @(negedge clk);
                cmd_done = 1'b0;
                cmd_fail = 1'b0;
            end else begin
                idle++;
                @(negedge clk);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    task automatic pulse(input bit en, input bit dis);
        @(negedge clk);
        enable_req  = en;
        disable_req = dis;
        @(negedge clk);
        enable_req  = 1'b0;
        disable_req = 1'b0;
    endtask

    // power-up with an optional failing command index; disturb = pulse disable mid-way
    task automatic run_up(input int f, input bit disturb);
        int n_exp;
        bit bad;
        cmd_count = 0;
        fail_at   = f;
        pulse(1'b1, 1'b0);
        chk(pwr_state == 2'd1, "R2", "state after enable", pwr_state, 1);
        chk(pwr_error == 1'b0, "R10", "error cleared on enable", pwr_error, 0);
        if (disturb) pulse(1'b1, 1'b1);
        while (pwr_state == 2'd1) @(negedge clk);
        bad   = (f >= 0 && f < 16);
        n_exp = (f >= 0 && f < 3) ? f + 1 : 16;
        chk(cmd_count == n_exp, (f >= 0 && f < 3) ? "R5" : "R2", "command count", cmd_count, n_exp);
        for (int k = 0; k < n_exp && k < cmd_count; k++) begin
            chk(cmd_log[k] == exp_cmd(k), "R2", $sformatf("up cmd %0d", k), cmd_log[k], exp_cmd(k));
            if (k >= 1 && k <= 3)
                chk(idle_log[k] >= DLY, "R3", $sformatf("pause before cmd %0d", k), idle_log[k], DLY);
        end
        chk(pwr_state == (bad ? 2'd0 : 2'd2), bad ? "R6" : "R7", "final state",
            pwr_state, bad ? 0 : 2);
        chk(pwr_error == bad, bad ? "R5" : "R7", "final error", pwr_error, bad);
    endtask

    task automatic run_down(input int f, input bit disturb);
        cmd_count = 0;
        fail_at   = f;
        pulse(1'b0, 1'b1);
        chk(pwr_state == 2'd3, "R8", "state after disable", pwr_state, 3);
        if (disturb) pulse(1'b1, 1'b0);
        while (pwr_state == 2'd3) @(negedge clk);
        chk(cmd_count == 4, "R8", "down count", cmd_count, 4);
        for (int k = 0; k < 4 && k < cmd_count; k++)
            chk(cmd_log[k] == exp_cmd(16 + k), "R8", $sformatf("down cmd %0d", k),
                cmd_log[k], exp_cmd(16 + k));
        chk(pwr_state == 2'd0, "R8", "state after down", pwr_state, 0);
        chk(pwr_error == 1'b0, "R8", "error after down", pwr_error, 0);
    endtask

    task automatic idle_check(input bit en, input bit dis, input logic [1:0] st);
        cmd_count = 0;
        pulse(en, dis);
        repeat (10) @(negedge clk);
        chk(pwr_state == st, "R9", "ignored request state", pwr_state, st);
        chk(cmd_count == 0, "R9", "ignored request commands", cmd_count, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(pwr_state == 2'd0, "R1", "reset state", pwr_state, 0);
        chk(pwr_error == 1'b0, "R1", "reset error", pwr_error, 0);
        chk(cmd_valid == 1'b0, "R1", "reset valid", cmd_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        idle_check(1'b0, 1'b1, 2'd0);        // R9 disable while disabled
        run_up(-1, 1'b0);                    // R2 R3 R7
        idle_check(1'b1, 1'b0, 2'd2);        // R9 enable while active
        run_down(-1, 1'b0);                  // R8
        run_up(1, 1'b0);                     // R5 abort on second zero
        run_up(0, 1'b0);                     // R5 abort on first
        run_up(2, 1'b0);                     // R5 abort on third
        run_up(10, 1'b0);                    // R6 late failure
        run_up(15, 1'b0);                    // R6 failure on display-on
        run_up(-1, 1'b1);                    // R9 requests during enabling, R10
        run_down(2, 1'b1);                   // R8 failure ignored, R9 enable while disabling

        for (int it = 0; it < 10; it++) begin
            int f;
            f = ($urandom_range(1, 0) == 1) ? -1 : int'($urandom_range(15, 0));
            run_up(f, $urandom_range(1, 0) == 1);
            if (pwr_state == 2'd2)
                run_down(($urandom_range(1, 0) == 1) ? int'($urandom_range(3, 0)) : -1,
                         $urandom_range(1, 0) == 1);
        end
        summary();
    end

endmodule